// File: doc/BRIEF.md
# Thermal Cruise Fan Duty Controller

This block closes a control loop between one temperature reading and one fan PWM output. A temperature sample arrives with a valid strobe. In thermal cruise mode the block moves an 8-bit duty value so that the temperature stays inside a band around a programmable target. When the temperature is above the band, the duty rises. When it is inside the band, the duty holds. When it is below the band, the duty falls in timed single-count steps toward a stop duty. After a programmable dwell at the stop duty, the fan switches off.

A fan that starts from standstill first receives a start-up kick: the duty jumps to a programmed start value. A control input can keep the fan at the stop duty so that it never switches off. When the fan has run at full duty for a programmed time and the temperature still stays above the target, a sticky warning flag is raised. A write-one-to-clear strobe clears the flag.

The duty is also turned into a PWM waveform of 256 slots per period. Manual mode passes a written duty straight through. All step, dwell and warning timings count in units of a common tick. The tick is a parameter with a 100 ms default, and the warning window defaults to three minutes of ticks.

Top module: `fan_cruise_ctrl`

## Requirements
- R1: After synchronous reset, duty is 0x00, pwm_out is low and warn is low.
- R2: With mode 2'b00 (manual) or 2'b11 (reserved, treated as manual), duty equals manual_duty one clock after it is presented.
- R3: With mode 2'b10 (speed cruise, not provided here), duty keeps its current value whatever manual_duty is.
- R4: In mode 2'b01 (thermal cruise), when the latched temperature is above target+tol and duty is 0x00, duty loads start_duty on the next clock.
- R5: In cruise mode, above the band with a nonzero duty, duty rises by one at each step event and saturates at 0xFF. A step event occurs every step_time ticks, and a step_time of 0 acts as 1.
- R6: In cruise mode, when the temperature is inside the band target-tol to target+tol (inclusive, with the low edge clamped at 0), duty holds.
- R7: In cruise mode, below the band, duty falls by one at each step event while it is above stop_duty, and never goes below stop_duty.
- R8: In cruise mode, below the band, once duty is nonzero and at or below stop_duty, it stays there for stop_time ticks and then becomes 0x00.
- R9: While hold_min is 1, the cruise loop never takes duty from the stop duty down to 0x00.
- R10: warn is set and stays set when the temperature is above target (not target+tol) and duty is 0xFF for WARN_TICKS consecutive ticks.
- R11: A one-clock pulse on warn_clr clears warn, unless the set condition of R10 holds in the same clock.
- R12: pwm_out is high for exactly duty of every 256 prescaled slots, so 0x00 never drives it high and 0xFF drives it high for 255 of 256 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_vld | input | 1 | Strobe that loads temp_in |
| temp_in | input | 8 | Unsigned temperature sample |
| mode | input | 2 | 00 manual, 01 thermal cruise, 10 speed cruise (holds duty), 11 as manual |
| manual_duty | input | 8 | Duty used in manual mode |
| target | input | 7 | Target temperature |
| tol | input | 4 | Band half-width around the target |
| start_duty | input | 8 | Kick duty used when the fan starts from 0 |
| stop_duty | input | 8 | Floor duty during ramp-down |
| stop_time | input | 8 | Dwell at the floor, in ticks |
| step_time | input | 8 | Ticks between duty steps (0 acts as 1) |
| hold_min | input | 1 | 1 keeps the fan at the floor instead of stopping it |
| warn_clr | input | 1 | Write-one-to-clear pulse for warn |
| duty | output | 8 | Current duty value |
| pwm_out | output | 1 | PWM waveform |
| warn | output | 1 | Sticky full-speed over-temperature warning |

## Verification
The assertions assume that the register inputs (target, tolerance, stop and start duties, the time values and the mode) do not change in the clock where a step or dwell decision is checked. Treating them as quasi-static configuration also lets the ramp and floor properties compare duty with its value one clock earlier. The stimulus changes configuration only at negative edges and between phases, and it always enters cruise mode from a known manual duty. The temperatures used sit clearly above, inside or below the band, so no check depends on a band edge in the same cycle as a sample update.

// File: rtl/fanctl_pkg.sv
package fanctl_pkg;
  typedef enum logic [1:0] {
    MODE_MANUAL = 2'b00,
    MODE_CRUISE = 2'b01,
    MODE_SPEED  = 2'b10,
    MODE_RSVD   = 2'b11
  } fan_mode_e;

  typedef enum logic [1:0] {
    ZONE_BAND = 2'b00,
    ZONE_HOT  = 2'b01,
    ZONE_COLD = 2'b10
  } temp_zone_e;
endpackage

// File: rtl/fan_tick_gen.sv
module fan_tick_gen #(
  parameter int TICK_CLKS = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/fan_cruise_core.sv
module fan_cruise_core
  import fanctl_pkg::*;
#(
  parameter int DW   = 8,
  parameter int TMW  = 8,
  parameter int TW   = 7,
  parameter int TOLW = 4,
  parameter int TCW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            temp_vld,
  input  logic [TMW-1:0]  temp_in,
  input  logic [1:0]      mode,
  input  logic [DW-1:0]   manual_duty,
  input  logic [TW-1:0]   target,
  input  logic [TOLW-1:0] tol,
  input  logic [DW-1:0]   start_duty,
  input  logic [DW-1:0]   stop_duty,
  input  logic [TCW-1:0]  stop_time,
  input  logic [TCW-1:0]  step_time,
  input  logic            hold_min,
  output logic [DW-1:0]   duty,
  output logic            over_target
);
  localparam int LW = TMW + 1;
  localparam logic [DW-1:0]  DMAX = {DW{1'b1}};
  localparam logic [TCW-1:0] TMAX = {TCW{1'b1}};

  fan_mode_e     m;
  temp_zone_e    zone;
  logic [TMW-1:0] temp_q;
  logic [LW-1:0]  hi_lim, lo_lim, temp_x;
  logic [TCW-1:0] step_cnt, dwell_cnt;
  logic [TCW:0]   step_lim;
  logic           step_ev, at_floor, dwell_done;
  logic [DW-1:0]  duty_nx;

  assign m = fan_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) temp_q <= '0;
    else if (temp_vld) temp_q <= temp_in;
  end

  always_comb begin
    temp_x = {1'b0, temp_q};
    hi_lim = LW'(target) + LW'(tol);
    lo_lim = (LW'(target) >= LW'(tol)) ? (LW'(target) - LW'(tol)) : '0;
    if (temp_x > hi_lim)      zone = ZONE_HOT;
    else if (temp_x < lo_lim) zone = ZONE_COLD;
    else                      zone = ZONE_BAND;
  end

  assign over_target = temp_x > LW'(target);

  // step interval timer
  assign step_lim = (step_time == '0) ? (TCW+1)'(1) : {1'b0, step_time};
  assign step_ev  = tick && (({1'b0, step_cnt} + (TCW+1)'(1)) >= step_lim);

  always_ff @(posedge clk) begin
    if (rst)          step_cnt <= '0;
    else if (step_ev) step_cnt <= '0;
    else if (tick)    step_cnt <= step_cnt + 1'b1;
  end

  // dwell at the floor duty
  assign at_floor   = (zone == ZONE_COLD) && (duty != '0) && (duty <= stop_duty);
  assign dwell_done = tick && (({1'b0, dwell_cnt} + (TCW+1)'(1)) >= {1'b0, stop_time});

  always_ff @(posedge clk) begin
    if (rst || !at_floor)          dwell_cnt <= '0;
    else if (tick && dwell_cnt != TMAX) dwell_cnt <= dwell_cnt + 1'b1;
  end

  always_comb begin
    duty_nx = duty;
    unique case (m)
      MODE_MANUAL, MODE_RSVD: duty_nx = manual_duty;
      MODE_SPEED:             duty_nx = duty;
      MODE_CRUISE: begin
        unique case (zone)
          ZONE_HOT: begin
            if (duty == '0)                    duty_nx = start_duty;
            else if (step_ev && duty != DMAX)  duty_nx = duty + 1'b1;
          end
          ZONE_COLD: begin
            if (duty > stop_duty) begin
              if (step_ev) duty_nx = duty - 1'b1;
            end else if (at_floor && dwell_done && !hold_min) begin
              duty_nx = '0;
            end
          end
          default: duty_nx = duty;
        endcase
      end
      default: duty_nx = duty;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) duty <= '0;
    else     duty <= duty_nx;
  end

  p_manual_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |=> duty == $past(manual_duty));

  p_speed_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> $stable(duty));

  p_kick_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && zone == ZONE_HOT && duty == '0) |=> duty == $past(start_duty));

  p_rise_one_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && zone == ZONE_HOT && duty != '0)
    |=> ({1'b0, duty} >= {1'b0, $past(duty)}) && ({1'b0, duty} <= {1'b0, $past(duty)} + 1'b1));

  p_band_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && zone == ZONE_BAND) |=> $stable(duty));

  p_fall_floor_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && zone == ZONE_COLD && duty > stop_duty && $stable(stop_duty))
    |=> (duty <= $past(duty)) && (duty >= $past(duty) - 1'b1) && (duty >= $past(stop_duty)));

  p_hold_min_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && hold_min && stop_duty != '0 && duty >= stop_duty) |=> duty != '0);
endmodule

// File: rtl/fan_warn_timer.sv
module fan_warn_timer #(
  parameter int DW         = 8,
  parameter int WARN_TICKS = 1800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          over_target,
  input  logic [DW-1:0] duty,
  input  logic          warn_clr,
  output logic          warn
);
  localparam int WCW = $clog2(WARN_TICKS + 1);
  localparam logic [WCW-1:0] LIM = WCW'(WARN_TICKS);

  logic [WCW-1:0] cnt;
  logic           cond;

  assign cond = over_target && (duty == {DW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || !cond)            cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                     warn <= 1'b0;
    else if (cond && cnt == LIM) warn <= 1'b1;
    else if (warn_clr)           warn <= 1'b0;
  end

  p_warn_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (warn && !warn_clr) |=> warn);

  p_warn_at_full_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(warn) |-> $past(duty) == {DW{1'b1}});

  p_warn_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (warn_clr && !cond) |=> !warn);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int DW      = 8,
  parameter int PRE_DIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] duty,
  output logic          pwm_out
);
  logic          slot_en;
  logic [DW-1:0] slot;

  generate
    if (PRE_DIV <= 1) begin : g_nodiv
      assign slot_en = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || pre == PW'(PRE_DIV - 1)) pre <= '0;
        else                                pre <= pre + 1'b1;
      end
      assign slot_en = (pre == PW'(PRE_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          slot <= '0;
    else if (slot_en) slot <= slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= (slot < duty);
  end

  p_pwm_zero_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(duty) == '0) |-> !pwm_out);
endmodule

// File: rtl/fan_cruise_ctrl.sv
module fan_cruise_ctrl #(
  parameter int TICK_CLKS  = 5_000_000,
  parameter int WARN_TICKS = 1800,
  parameter int PRE_DIV    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       temp_vld,
  input  logic [7:0] temp_in,
  input  logic [1:0] mode,
  input  logic [7:0] manual_duty,
  input  logic [6:0] target,
  input  logic [3:0] tol,
  input  logic [7:0] start_duty,
  input  logic [7:0] stop_duty,
  input  logic [7:0] stop_time,
  input  logic [7:0] step_time,
  input  logic       hold_min,
  input  logic       warn_clr,
  output logic [7:0] duty,
  output logic       pwm_out,
  output logic       warn
);
  localparam int DW = 8;

  logic tick;
  logic over_target;

  fan_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  fan_cruise_core #(.DW(DW), .TMW(8), .TW(7), .TOLW(4), .TCW(8)) u_core (
    .clk(clk), .rst(rst), .tick(tick),
    .temp_vld(temp_vld), .temp_in(temp_in), .mode(mode),
    .manual_duty(manual_duty), .target(target), .tol(tol),
    .start_duty(start_duty), .stop_duty(stop_duty),
    .stop_time(stop_time), .step_time(step_time), .hold_min(hold_min),
    .duty(duty), .over_target(over_target)
  );

  fan_warn_timer #(.DW(DW), .WARN_TICKS(WARN_TICKS)) u_warn (
    .clk(clk), .rst(rst), .tick(tick), .over_target(over_target),
    .duty(duty), .warn_clr(warn_clr), .warn(warn)
  );

  fan_pwm_gen #(.DW(DW), .PRE_DIV(PRE_DIV)) u_pwm (
    .clk(clk), .rst(rst), .duty(duty), .pwm_out(pwm_out)
  );
endmodule

// File: tb/fan_cruise_ctrl_tb.sv
module fan_cruise_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       temp_vld = 1'b0;
  logic [7:0] temp_in = '0;
  logic [1:0] mode = 2'b00;
  logic [7:0] manual_duty = '0;
  logic [6:0] target = 7'd50;
  logic [3:0] tol = 4'd3;
  logic [7:0] start_duty = 8'd200;
  logic [7:0] stop_duty = 8'd100;
  logic [7:0] stop_time = 8'd200;
  logic [7:0] step_time = 8'd1;
  logic       hold_min = 1'b0;
  logic       warn_clr = 1'b0;
  logic [7:0] duty;
  logic       pwm_out;
  logic       warn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_cruise_ctrl #(.TICK_CLKS(4), .WARN_TICKS(20), .PRE_DIV(1)) u_dut (
    .clk(clk), .rst(rst), .temp_vld(temp_vld), .temp_in(temp_in),
    .mode(mode), .manual_duty(manual_duty), .target(target), .tol(tol),
    .start_duty(start_duty), .stop_duty(stop_duty), .stop_time(stop_time),
    .step_time(step_time), .hold_min(hold_min), .warn_clr(warn_clr),
    .duty(duty), .pwm_out(pwm_out), .warn(warn)
  );

  // {mode, manual_duty, expected duty}
  localparam logic [17:0] VEC [6] = '{
    {2'b00, 8'h00, 8'h00},
    {2'b00, 8'h5A, 8'h5A},
    {2'b11, 8'hC3, 8'hC3},
    {2'b10, 8'h11, 8'hC3},
    {2'b00, 8'hFF, 8'hFF},
    {2'b10, 8'h22, 8'hFF}
  };

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic set_temp(input logic [7:0] t);
    temp_in  = t;
    temp_vld = 1'b1;
    @(negedge clk);
    temp_vld = 1'b0;
  endtask

  task automatic pwm_high_count(output int hi);
    hi = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    int hi;
    wait_clks(3);
    rst = 1'b0;
    wait_clks(1);
    chk("R1 duty", duty, 0);
    chk("R1 pwm", pwm_out, 0);
    chk("R1 warn", warn, 0);

    for (int i = 0; i < 6; i++) begin
      mode        = VEC[i][17:16];
      manual_duty = VEC[i][15:8];
      wait_clks(2);
      if (VEC[i][17:16] == 2'b10) chk("R3 speed mode holds", duty, VEC[i][7:0]);
      else                        chk("R2 manual duty", duty, VEC[i][7:0]);
    end

    // R12 PWM high count per 256 slots
    mode = 2'b00;
    manual_duty = 8'h00; wait_clks(3); pwm_high_count(hi); chk("R12 pwm 00", hi, 0);
    manual_duty = 8'h40; wait_clks(3); pwm_high_count(hi); chk("R12 pwm 40", hi, 64);
    manual_duty = 8'hFF; wait_clks(3); pwm_high_count(hi); chk("R12 pwm FF", hi, 255);

    // R6 in band holds
    manual_duty = 8'h80;
    set_temp(8'd50);
    wait_clks(2);
    mode = 2'b01;
    wait_clks(200);
    chk("R6 band hold", duty, 8'h80);

    // R4 kick from zero
    mode = 2'b00; manual_duty = 8'h00;
    set_temp(8'd60);
    wait_clks(2);
    mode = 2'b01;
    wait_clks(1);
    chk("R4 kick", duty, 200);

    // R5 ramp up and R10 warning
    wait_clks(150);
    chk_rng("R5 rising", duty, 201, 254);
    chk("R10 no warn before full", warn, 0);
    wait_clks(250);
    chk("R5 saturate", duty, 255);
    chk("R10 warn set", warn, 1);

    set_temp(8'd50);
    wait_clks(20);
    chk("R10 warn sticky", warn, 1);
    chk("R6 band holds full", duty, 255);
    warn_clr = 1'b1; wait_clks(1); warn_clr = 1'b0;
    wait_clks(1);
    chk("R11 warn cleared", warn, 0);
    wait_clks(100);
    chk("R11 stays clear", warn, 0);

    // R7 + R9 ramp down with hold at minimum
    hold_min = 1'b1;
    set_temp(8'd40);
    wait_clks(200);
    chk_rng("R7 falling", duty, 101, 254);
    wait_clks(500);
    chk("R7 floor", duty, 100);
    wait_clks(1000);
    chk("R9 hold min", duty, 100);

    // R8 dwell then stop
    set_temp(8'd60);
    wait_clks(700);
    chk("R5 re-ramp", duty, 255);
    hold_min = 1'b0;
    set_temp(8'd40);
    wait_clks(1200);
    chk("R8 dwell at floor", duty, 100);
    wait_clks(500);
    chk("R8 stop after dwell", duty, 0);
    chk("R12 pwm low at zero", pwm_out, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule